// File: doc/BRIEF.md
# Bus Memory Map Decoder

This block sits on a CPU bus with a 16-bit address and an 8-bit data path. It decodes each access into one of five active-low device selects: a read-only program device in the lowest 8K, three 8K user RAM banks directly above it, and a 2K work RAM at the very top of the address space. The address decode works in two stages. A 3-to-8 decode of the three highest address bits picks an 8K slot. The top slot is then narrowed by two further address bits to a 2K window. Everything between the user banks and that window is unmapped.

Behind the selects sits a behavioural storage model, so the whole read and write path can be tested from the bus pins. Read data comes combinationally from whichever device is selected. Writes land on the rising clock edge. The program device is filled with a computed pattern during reset and refuses writes. The model keeps only the low `STORE_AW` bits of each device offset, which holds storage small while keeping the decode at full width. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `mem_map_ctrl`

## Requirements
- R1: With the request active (bus_req_n=0), an address in 0x0000–0x1FFF asserts only dev_sel_n[0]. Reads there return rom_byte(k) = ((k*37) xor 0xA5) mod 256, where k is address bits 7:0.
- R2: With the request active, address bits 15:13 equal to 1, 2 or 3 assert only dev_sel_n[1], dev_sel_n[2] or dev_sel_n[3] respectively.
- R3: With the request active, an address in 0xF800–0xFFFF (bits 15:13 all 1 and bits 12 and 11 both 1) asserts only dev_sel_n[4]. Addresses 0xE000–0xF7FF assert none.
- R4: A write cycle aimed at 0x0000–0x1FFF leaves every read-only byte unchanged.
- R5: No more than one bit of dev_sel_n is low at any time.
- R6: While bus_req_n is 1, every dev_sel_n bit is 1, bus_rdata is 0xFF and no storage changes.
- R7: Addresses 0x8000–0xF7FF read 0xFF, and writes to them change no stored byte.
- R8: A write happens on the rising clock edge while bus_req_n=0 and bus_rd_nwr=0. From then on the written byte is visible combinationally on bus_rdata whenever that location is addressed with the request active.
- R9: An 8K device is addressed by bits 12:0 and the 2K device by bits 10:0. The model keeps offset bits STORE_AW-1:0 (8 by default), so offsets that agree in those bits reach the same byte.
- R10: After reset, every RAM byte reads 0x00 and the read-only device holds rom_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_req_n | input | 1 | Active-low memory request |
| bus_rdata | output | 8 | Read data, 0xFF when no device is selected |
| dev_sel_n | output | 5 | Active-low selects: 0 program, 1–3 user banks, 4 work RAM |

## Verification
The hardest case to reach from the ports is two different bus addresses that land on the same stored byte. This happens when they differ only in offset bits above the modelled width, or in the work RAM when they differ in bits 10:8. A uniformly random address hits such a pair only rarely before one of the bytes is rewritten. The stimulus therefore includes directed pairs that write one address and read back through its alias. The random traffic is also biased toward a few small offset pools, so collisions happen often while a bench-side storage image keeps track of every byte.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int N_DEV    = 5;
  localparam int SLOT_W   = 3;
  localparam int BIG_AW   = 13;
  localparam int SMALL_AW = 11;
  localparam logic [DATA_W-1:0] IDLE_DATA = 8'hFF;

  typedef enum logic [2:0] {
    DEV_PROG  = 3'd0,
    DEV_USER1 = 3'd1,
    DEV_USER2 = 3'd2,
    DEV_USER3 = 3'd3,
    DEV_WORK  = 3'd4
  } dev_e;

  function automatic logic [DATA_W-1:0] rom_byte(input int unsigned k);
    int unsigned v;
    v = (k * 37) ^ 32'hA5;
    return v[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/mmap_decode.sv
module mmap_decode
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              a12,
  input  logic              a11,
  output logic [N_DEV-1:0]  sel_n
);
  localparam int N_SLOT = 1 << SLOT_W;

  logic [N_SLOT-1:0] slot_n;

  // 3-to-8 decode, all outputs inactive without a request
  genvar g;
  generate
    for (g = 0; g < N_SLOT; g++) begin : g_slot
      assign slot_n[g] = req_n | (slot != SLOT_W'(g));
    end
  endgenerate

  always_comb begin
    sel_n[DEV_PROG]  = slot_n[0];
    sel_n[DEV_USER1] = slot_n[1];
    sel_n[DEV_USER2] = slot_n[2];
    sel_n[DEV_USER3] = slot_n[3];
    sel_n[DEV_WORK]  = ~(~slot_n[N_SLOT-1] & a12 & a11);
  end

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));

  a_r6_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    req_n |-> (sel_n == '1));

  a_r3_gap_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && slot == 3'd7 && !(a12 && a11)) |-> (sel_n == '1));
endmodule

// File: rtl/mmap_store.sv
module mmap_store
  import mmap_pkg::*;
#(
  parameter int STORE_AW = 8,
  parameter bit WRITABLE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr_req,
  input  logic [STORE_AW-1:0] ofs,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  generate
    if (WRITABLE) begin : g_ram
      logic              wr_en;
      logic [DATA_W-1:0] mem_d [DEPTH];

      assign wr_en = sel & wr_req;

      always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[ofs] = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
          mem_q <= mem_d;
        end
      end

      a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(ofs)] == $past(wdata)));
    end else begin : g_rom
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= rom_byte(i);
        end
      end
    end
  endgenerate

  assign rdata = mem_q[ofs];
endmodule

// File: rtl/mem_map_ctrl.sv
module mem_map_ctrl
  import mmap_pkg::*;
#(
  parameter int STORE_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd_nwr,
  input  logic              bus_req_n,
  output logic [7:0]        bus_rdata,
  output logic [4:0]        dev_sel_n
);
  localparam int N_USER = 3;

  logic [1:0]        rst_q;
  logic              rst_sync_n;
  logic              wr_req;
  logic [DATA_W-1:0] dev_rdata [N_DEV];

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  assign wr_req = ~bus_req_n & ~bus_rd_nwr;

  mmap_decode i_decode (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req_n (bus_req_n),
    .slot  (bus_addr[ADDR_W-1 -: SLOT_W]),
    .a12   (bus_addr[12]),
    .a11   (bus_addr[11]),
    .sel_n (dev_sel_n)
  );

  generate
    if (STORE_AW > SMALL_AW) begin : g_bad_param
      $error("STORE_AW exceeds the smallest device offset");
    end
  endgenerate

  mmap_store #(.STORE_AW(STORE_AW), .WRITABLE(1'b0)) i_prog (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel    (~dev_sel_n[DEV_PROG]),
    .wr_req (wr_req),
    .ofs    (bus_addr[STORE_AW-1:0]),
    .wdata  (bus_wdata),
    .rdata  (dev_rdata[DEV_PROG])
  );

  genvar u;
  generate
    for (u = 1; u <= N_USER; u++) begin : g_user
      mmap_store #(.STORE_AW(STORE_AW), .WRITABLE(1'b1)) i_bank (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .sel    (~dev_sel_n[u]),
        .wr_req (wr_req),
        .ofs    (bus_addr[STORE_AW-1:0]),
        .wdata  (bus_wdata),
        .rdata  (dev_rdata[u])
      );
    end
  endgenerate

  mmap_store #(.STORE_AW(STORE_AW), .WRITABLE(1'b1)) i_work (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel    (~dev_sel_n[DEV_WORK]),
    .wr_req (wr_req),
    .ofs    (bus_addr[STORE_AW-1:0]),
    .wdata  (bus_wdata),
    .rdata  (dev_rdata[DEV_WORK])
  );

  always_comb begin
    bus_rdata = IDLE_DATA;
    for (int d = 0; d < N_DEV; d++) begin
      if (!dev_sel_n[d]) bus_rdata = dev_rdata[d];
    end
  end

  a_r7_unmapped_reads_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_req_n && bus_addr >= 16'h8000 && bus_addr < 16'hF800) |-> (bus_rdata == IDLE_DATA));

  a_r4_prog_write_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_req && bus_addr < 16'h2000) |=>
      (bus_req_n || bus_addr != $past(bus_addr) || bus_rdata == $past(bus_rdata)));

  a_r2_bank_select: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_req_n && bus_addr[15:13] == 3'd2) |-> (dev_sel_n == 5'b11011));
endmodule

// File: tb/test_mem_map_ctrl.sv
module test_mem_map_ctrl;
  localparam int CLK_P    = 10;
  localparam int STORE_AW = 8;
  localparam int DEPTH    = 1 << STORE_AW;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd_nwr;
  logic        bus_req_n;
  logic [7:0]  bus_rdata;
  logic [4:0]  dev_sel_n;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [7:0] img [4][DEPTH];   // 0..2 user banks, 3 work RAM

  mem_map_ctrl #(.STORE_AW(STORE_AW)) i_mem_map_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd_nwr(bus_rd_nwr), .bus_req_n(bus_req_n), .bus_rdata(bus_rdata),
    .dev_sel_n(dev_sel_n)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] prog_byte(input int unsigned k);
    int unsigned v;
    v = (k * 37) ^ 32'hA5;
    return v[7:0];
  endfunction

  // -1 means no device
  function automatic int region(input logic [15:0] a);
    if (a < 16'h2000) return 0;
    if (a < 16'h4000) return 1;
    if (a < 16'h6000) return 2;
    if (a < 16'h8000) return 3;
    if (a >= 16'hF800) return 4;
    return -1;
  endfunction

  function automatic logic [4:0] exp_sel(input logic [15:0] a, input logic req_n);
    int r;
    r = region(a);
    if (req_n || r < 0) return 5'b11111;
    return ~(5'b00001 << r);
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [15:0] a, input logic req_n);
    int r;
    r = region(a);
    if (req_n || r < 0) return 8'hFF;
    if (r == 0) return prog_byte(a[STORE_AW-1:0]);
    return img[r-1][a[STORE_AW-1:0]];
  endfunction

  function automatic string tag_of(input logic [15:0] a, input logic req_n);
    int r;
    r = region(a);
    if (req_n) return "R6";
    if (r == 0) return "R1";
    if (r == 4) return "R3";
    if (r > 0) return "R2";
    return "R7";
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one bus cycle at the falling edge, check before the rising edge
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rd, input logic req_n);
    int r;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd_nwr = rd; bus_req_n = req_n;
    #1;
    check(tag_of(a, req_n), "select", {3'b000, dev_sel_n}, {3'b000, exp_sel(a, req_n)});
    check(tag_of(a, req_n), "rdata", bus_rdata, exp_rdata(a, req_n));
    r = region(a);
    @(posedge clk);
    if (!req_n && !rd && r > 0) img[r-1][a[STORE_AW-1:0]] = d;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd_nwr = 1'b1; bus_req_n = 1'b0;
    #1;
    check(tag, "readback", bus_rdata, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < DEPTH; i++) img[b][i] = 8'h00;
    rst_n = 1'b0; bus_addr = 16'h0; bus_wdata = 8'h0; bus_rd_nwr = 1'b1; bus_req_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R6 / R10 reset and idle state
    #1;
    check("R6", "idle select", {3'b000, dev_sel_n}, 8'h1F);
    check("R6", "idle rdata", bus_rdata, 8'hFF);
    rd_chk("R10", 16'h2000, 8'h00);
    rd_chk("R10", 16'hFFFF, 8'h00);
    rd_chk("R10", 16'h0000, prog_byte(0));
    rd_chk("R1",  16'h1FFF, prog_byte(8'hFF));

    // boundaries of the map
    bus_cycle(16'h1FFF, 8'h00, 1'b1, 1'b0);
    bus_cycle(16'h2000, 8'h00, 1'b1, 1'b0);
    bus_cycle(16'h7FFF, 8'h00, 1'b1, 1'b0);
    bus_cycle(16'h8000, 8'h00, 1'b1, 1'b0);
    bus_cycle(16'hE000, 8'h00, 1'b1, 1'b0);
    bus_cycle(16'hF7FF, 8'h00, 1'b1, 1'b0);
    bus_cycle(16'hF800, 8'h00, 1'b1, 1'b0);
    bus_cycle(16'hFFFF, 8'h00, 1'b1, 1'b0);

    // R4 program region write protection
    bus_cycle(16'h0010, 8'h3C, 1'b0, 1'b0);
    rd_chk("R4", 16'h0010, prog_byte(8'h10));

    // R8 write then combinational readback
    bus_cycle(16'h4321, 8'h5A, 1'b0, 1'b0);
    rd_chk("R8", 16'h4321, 8'h5A);

    // R9 aliasing above the stored offset bits
    bus_cycle(16'h2005, 8'h11, 1'b0, 1'b0);
    bus_cycle(16'h3F05, 8'h22, 1'b0, 1'b0);
    rd_chk("R9", 16'h2005, 8'h22);
    bus_cycle(16'hF805, 8'h33, 1'b0, 1'b0);
    rd_chk("R9", 16'hFD05, 8'h33);

    // R6 write with the request inactive must not store
    bus_cycle(16'h6007, 8'h99, 1'b0, 1'b1);
    rd_chk("R6", 16'h6007, 8'h00);

    // R7 unmapped write leaves storage untouched
    bus_cycle(16'hA005, 8'h77, 1'b0, 1'b0);
    rd_chk("R7", 16'h2005, 8'h22);
    rd_chk("R7", 16'hF805, 8'h33);

    // constrained random traffic with small offset pools
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [2:0]  pick;
      pick = 3'($urandom_range(0, 7));
      a = 16'($urandom);
      if (pick < 5) a[7:0] = 8'($urandom_range(0, 7));
      if (pick == 5) a[15:11] = 5'b11111;
      bus_cycle(a, 8'($urandom), 1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0));
    end

    // final sweep of every modelled byte in each RAM
    for (int i = 0; i < DEPTH; i++) begin
      rd_chk("R8", 16'h2000 + 16'(i), img[0][i]);
      rd_chk("R8", 16'h4000 + 16'(i), img[1][i]);
      rd_chk("R8", 16'h6000 + 16'(i), img[2][i]);
      rd_chk("R8", 16'hF800 + 16'(i), img[3][i]);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule